// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block is a memory-mapped pulse-width-modulation generator with up to eight independent channels behind one 32-bit register port that has simple write and read strobes. Each channel divides the system clock by a power of two chosen in its control register. It counts through a programmable period in those divided ticks and drives its output high while the count is below a programmable threshold. One shared register holds an enable bit for every channel, so software turns channels on and off with read-modify-write cycles on that single word.

The channel register banks sit at fixed, irregular base offsets. A build-time option moves the width and threshold registers of every channel above index 2 by one word. New period, threshold and divider values are staged and take effect only when the running period ends, so software can retune a live output without producing a glitch. The channel count (1, 4, 5, 6 or 8) and the alternate register placement are parameters.

Top module: `multi_pwm`

## Requirements
- R1: After synchronous reset, every output is low, the enable word reads 0 and every channel register reads 0.
- R2: The enable word is at offset 0x000, and its bit n enables channel n. Channel n's bank base is 0x010, 0x050, 0x090, 0x0D0, 0x110, 0x150, 0x190 or 0x220 for n = 0..7. The control register is at base+0x00 and keeps bit 15 (run mode) and bits 2:0 (divider exponent), with other bits reading 0. The period register is at base+0x2C and the threshold register is at base+0x30; both keep 13 bits.
- R3: With the alternate placement option set, channels 3 and above hold the period register at base+0x30 and the threshold register at base+0x34, and base+0x2C is unmapped for them. Channels 0 to 2 keep the normal placement.
- R4: A read of an unmapped offset returns 0, including a bank of a channel at or above the channel count and any offset that is not word-aligned. A write to an unmapped offset changes no register.
- R5: A running channel advances its counter once every 2^div clocks, where div is the control register's bits 2:0. The counter runs from 0 to the period value and then wraps to 0, so one waveform lasts (period+1)*2^div clocks.
- R6: The output is high while the counter is below the threshold. A threshold of 0 gives a constant low output. Otherwise, a threshold greater than or equal to the period gives a constant high output.
- R7: A channel runs only while both its enable bit and its control bit 15 are set. Otherwise its output is low and its counter and prescaler are cleared. Enabling a channel starts a fresh period at count 0.
- R8: Period, threshold and divider writes to a running channel take effect only at the next wrap of its counter.
- R9: Read data appears on rdata on the clock edge that samples rd_en and then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte offset from the block base |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| pwm_o | output | NCH | One PWM output per channel |

## Verification
A write lands on the edge that samples the strobe. An enable or disable therefore shows on the output at the very next falling-edge sample, and the bench checks the output level there, with no extra wait. Read data is due one cycle after rd_en, so the read task samples rdata at the falling edge that follows the sampling edge. Waveform checks count high samples over exactly (period+1)*2^div clocks, starting at the sample right after the enabling write, which lines the window up with the fresh period. The staged-update check counts the remainder of the current period, where the old threshold must still apply, and then the following full period, where the new one must.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;

    localparam int CNT_W    = 13;   // period and threshold width
    localparam int DIV_W    = 3;    // divider exponent width
    localparam int MODE_POS = 15;   // run-mode bit in the control word
    localparam int MAX_CH   = 8;

    typedef struct packed {
        logic             mode;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] thr;
    } chan_cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_CTRL,
        SEL_PERIOD,
        SEL_THRESH
    } reg_sel_e;

    // Bank base of a channel; the spacing is not uniform.
    function automatic logic [11:0] bank_base(input int unsigned ch);
        case (ch)
            0:       return 12'h010;
            1:       return 12'h050;
            2:       return 12'h090;
            3:       return 12'h0D0;
            4:       return 12'h110;
            5:       return 12'h150;
            6:       return 12'h190;
            default: return 12'h220;
        endcase
    endfunction

    function automatic logic [11:0] period_off(input bit alt, input int unsigned ch);
        return (alt && ch > 2) ? 12'h030 : 12'h02C;
    endfunction

    function automatic logic [11:0] thresh_off(input bit alt, input int unsigned ch);
        return (alt && ch > 2) ? 12'h034 : 12'h030;
    endfunction

    // Output level for a running channel.
    function automatic logic wave_level(input logic [CNT_W-1:0] cnt,
                                        input logic [CNT_W-1:0] thr,
                                        input logic [CNT_W-1:0] per);
        if (thr == '0)
            return 1'b0;
        else if (thr >= per)
            return 1'b1;
        else
            return (cnt < thr);
    endfunction

endpackage

// File: rtl/pwm_decode.sv
module pwm_decode
    import pwmx_pkg::*;
#(
    parameter int NCH     = 8,
    parameter bit ALT_MAP = 1'b0,
    parameter int ADDR_W  = 12,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [CH_W-1:0]   ch
);

    always_comb begin
        sel = SEL_NONE;
        ch  = '0;
        if (addr == '0)
            sel = SEL_ENABLE;
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(bank_base(i))) begin
                sel = SEL_CTRL;
                ch  = CH_W'(i);
            end
            if (addr == ADDR_W'(bank_base(i) + period_off(ALT_MAP, i))) begin
                sel = SEL_PERIOD;
                ch  = CH_W'(i);
            end
            if (addr == ADDR_W'(bank_base(i) + thresh_off(ALT_MAP, i))) begin
                sel = SEL_THRESH;
                ch  = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwmx_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DATA_W = 32,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [CH_W-1:0]   ch,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    en,
    output chan_cfg_t         cfg [NCH]
);

    logic [DATA_W-1:0] rd_val;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_ENABLE: rd_val = DATA_W'(en);
            SEL_CTRL: begin
                rd_val[MODE_POS]  = cfg[ch].mode;
                rd_val[DIV_W-1:0] = cfg[ch].div;
            end
            SEL_PERIOD: rd_val = DATA_W'(cfg[ch].per);
            SEL_THRESH: rd_val = DATA_W'(cfg[ch].thr);
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= '0;
            rdata <= '0;
            for (int i = 0; i < NCH; i++)
                cfg[i] <= '0;
        end else begin
            if (wr_en) begin
                case (sel)
                    SEL_ENABLE: en <= wdata[NCH-1:0];
                    SEL_CTRL: begin
                        cfg[ch].mode <= wdata[MODE_POS];
                        cfg[ch].div  <= wdata[DIV_W-1:0];
                    end
                    SEL_PERIOD: cfg[ch].per <= wdata[CNT_W-1:0];
                    SEL_THRESH: cfg[ch].thr <= wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (rd_en)
                rdata <= rd_val;
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwmx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);

    localparam int PRE_W = (1 << DIV_W) - 1;

    logic             run;
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] pre_lim;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] act_div;
    logic [CNT_W-1:0] act_per;
    logic [CNT_W-1:0] act_thr;

    assign run     = en_i & cfg_i.mode;
    assign pre_lim = ~({PRE_W{1'b1}} << act_div);
    assign tick    = (pre == pre_lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            // Idle: clear the counters and track the programmed values.
            pre     <= '0;
            cnt     <= '0;
            act_div <= cfg_i.div;
            act_per <= cfg_i.per;
            act_thr <= cfg_i.thr;
        end else if (tick) begin
            pre <= '0;
            if (cnt >= act_per) begin
                cnt     <= '0;
                act_div <= cfg_i.div;
                act_per <= cfg_i.per;
                act_thr <= cfg_i.thr;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assign pwm_o = run & wave_level(cnt, act_thr, act_per);

endmodule

// File: rtl/multi_pwm.sv
module multi_pwm
    import pwmx_pkg::*;
#(
    parameter int NCH     = 8,     // 1, 4, 5, 6 or 8
    parameter bit ALT_MAP = 1'b0,  // moved period/threshold for channels above 2
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    pwm_o
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    reg_sel_e        sel;
    logic [CH_W-1:0] ch;
    logic [NCH-1:0]  en;
    chan_cfg_t       cfg [NCH];

    pwm_decode #(.NCH(NCH), .ALT_MAP(ALT_MAP), .ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel),
        .ch   (ch)
    );

    pwm_regs #(.NCH(NCH), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .sel   (sel),
        .ch    (ch),
        .wdata (wdata),
        .rdata (rdata),
        .en    (en),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwm_chan u_chan (
            .clk   (clk),
            .rst   (rst),
            .en_i  (en[g]),
            .cfg_i (cfg[g]),
            .pwm_o (pwm_o[g])
        );
    end

endmodule

// File: rtl/pwm_chk.sv
module pwm_chk #(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [NCH-1:0]    pwm_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (pwm_o == '0));

    // R1
    reset_rdata_chk: assert property (@(posedge clk) rst |=> (rdata == '0));

    // R4
    misaligned_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[1:0] != 2'b00) |=> (rdata == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    for (genvar g = 0; g < NCH; g++) begin : g_off
        // R7
        disable_low_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == '0 && !wdata[g]) |=> !pwm_o[g]);
    end

endmodule

bind multi_pwm pwm_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .pwm_o (pwm_o)
);

// File: tb/multi_pwm_tb_top.sv
`timescale 1ns/1ps
module multi_pwm_tb_top;

    typedef struct packed {
        logic [2:0]  div;
        logic [12:0] per;
        logic [12:0] thr;
        int unsigned high;   // expected high clocks in one waveform
    } vec_t;

    // R5 R6: high clocks = thr==0 ? 0 : thr>=per ? (per+1)<<div : thr<<div
    localparam vec_t VECS [8] = '{
        '{3'd0, 13'd9,  13'd3,  32'd3},
        '{3'd1, 13'd9,  13'd5,  32'd10},
        '{3'd2, 13'd4,  13'd2,  32'd8},
        '{3'd0, 13'd7,  13'd0,  32'd0},
        '{3'd0, 13'd7,  13'd7,  32'd8},
        '{3'd7, 13'd2,  13'd1,  32'd128},
        '{3'd0, 13'd0,  13'd1,  32'd1},
        '{3'd2, 13'd10, 13'd10, 32'd44}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_alt;
    logic [7:0]  pwm_o;
    logic [4:0]  pwm_alt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    multi_pwm #(.NCH(8), .ALT_MAP(1'b0)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
    );

    multi_pwm #(.NCH(5), .ALT_MAP(1'b1)) dut_alt_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_alt), .pwm_o(pwm_alt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] da);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
        d  = rdata;
        da = rdata_alt;
    endtask

    // Samples bit b at the current falling edge and n-1 following ones,
    // ending on the falling edge after the last sample.
    task automatic measure(input int n, input int b, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_o[b]) hi++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d, da;
        int hi;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 outputs", {24'd0, pwm_o}, 32'd0);
        rd(12'h000, d, da);
        check("R1 enable word", d, 32'd0);
        rd(12'h220, d, da);
        check("R1 ctrl ch7", d, 32'd0);

        // R2 masking and bank placement
        wr(12'h010, 32'hFFFF_FFFD);
        rd(12'h010, d, da);
        check("R2 ctrl mask", d, 32'h0000_8005);
        wr(12'h24C, 32'h0000_FFFF);
        rd(12'h24C, d, da);
        check("R2 period ch7", d, 32'h0000_1FFF);
        wr(12'h1C0, 32'h55);
        rd(12'h1C0, d, da);
        check("R2 thresh ch6", d, 32'h55);
        rd(12'h250, d, da);
        check("R2 thresh ch7 separate", d, 32'h0);

        // R4 unmapped write/read
        wr(12'h004, 32'hFF);
        rd(12'h004, d, da);
        check("R4 unmapped read", d, 32'h0);
        rd(12'h000, d, da);
        check("R4 enable untouched", d, 32'h0);
        rd(12'h013, d, da);
        check("R4 misaligned read", d, 32'h0);

        // R9 read data holds
        rd(12'h010, d, da);
        repeat (3) @(negedge clk);
        check("R9 rdata hold", rdata, 32'h0000_8005);

        // R5 R6 vector table on channel 0
        foreach (VECS[k]) begin
            wr(12'h000, 32'h0);
            wr(12'h010, 32'h8000 | 32'(VECS[k].div));
            wr(12'h03C, 32'(VECS[k].per));
            wr(12'h040, 32'(VECS[k].thr));
            wr(12'h000, 32'h1);
            measure((VECS[k].per + 1) << VECS[k].div, 0, hi);
            check($sformatf("R5 R6 vector %0d", k), hi, VECS[k].high);
        end

        // R7 mode bit clear keeps output low
        wr(12'h000, 32'h0);
        wr(12'h010, 32'h0000);
        wr(12'h03C, 32'd9);
        wr(12'h040, 32'd5);
        wr(12'h000, 32'h1);
        measure(10, 0, hi);
        check("R7 mode bit clear", hi, 0);

        // R7 only the addressed enable bit runs a channel
        wr(12'h010, 32'h8000);
        wr(12'h000, 32'h2);
        measure(10, 0, hi);
        check("R7 other enable bit", hi, 0);

        // R8 staged threshold change
        wr(12'h000, 32'h0);
        wr(12'h040, 32'd3);
        wr(12'h000, 32'h1);
        repeat (3) @(negedge clk);
        wr(12'h040, 32'd8);
        measure(5, 0, hi);
        check("R8 old threshold kept", hi, 0);
        measure(10, 0, hi);
        check("R8 new threshold at wrap", hi, 8);

        // R7 disable and fresh restart
        wr(12'h000, 32'h0);
        check("R7 disabled low", pwm_o[0], 1'b0);
        wr(12'h000, 32'h1);
        check("R7 restart high", pwm_o[0], 1'b1);
        measure(10, 0, hi);
        check("R7 restart period", hi, 8);

        // R3 alternate placement
        wr(12'h100, 32'hAB);
        wr(12'h104, 32'hCD);
        rd(12'h100, d, da);
        check("R3 alt period ch3", da, 32'hAB);
        rd(12'h104, d, da);
        check("R3 alt thresh ch3", da, 32'hCD);
        rd(12'h0FC, d, da);
        check("R3 alt old slot unmapped", da, 32'h0);
        wr(12'h07C, 32'h11);
        rd(12'h07C, d, da);
        check("R3 alt ch1 normal", da, 32'h11);

        // R4 bank beyond channel count
        wr(12'h150, 32'h8003);
        rd(12'h150, d, da);
        check("R4 missing channel", da, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule